// File: doc/BRIEF.md
# CPU Trace Capture Unit

This block records CPU bus activity into a 64-entry circular trace memory for later inspection. Each clock it is offered three kinds of activity: a bus cycle (cycle type, address, data, access width and direction), a change-of-flow event (source, destination or vector address), and an opcode-execution event carrying the program counter. A two-bit mode input chooses which of these is recorded, and how:

- **Flow mode** stores every change-of-flow address.
- **Loop-filter mode** does the same, but drops a source address that repeats the last stored address, so that a tight loop cannot flood the memory.
- **Access mode** stores the address and data of each data access, together with an information byte. It can be restricted to an inclusive address window.
- **PC mode** stores the program counter of every executed opcode.

Stored entries are read back through an index port, where index 0 is the oldest valid entry. A count output tells how many entries are valid. A synchronous clear empties the memory and forgets the loop filter's remembered address.

Top module: `trace_capture`

## Requirements
- R1: In flow mode (mode 0), each `cofValid` with `cofKind` 0 (source), 1 (destination) or 2 (vector) stores one entry. The entry has tag = `cofKind`, address = `cofAddr`, info 0 and data 0. Repeated identical events are all stored. `cofKind` 3, bus cycles and execution events store nothing.
- R2: In loop-filter mode (mode 1), every stored entry copies its address into a shadow register. A source event whose address equals a valid shadow value is dropped. Otherwise the mode stores entries as in R1.
- R3: In loop-filter mode, destination and vector events are stored even when their address equals the shadow value.
- R4: In access mode (mode 2), each traced bus cycle stores tag 3, `busAddr` and `busData`, and an info byte with bit 0 = word access and bit 1 = write (all other bits 0). Change-of-flow and execution events store nothing.
- R5: In access mode, cycles with `cycType` 0 (free) or 1 (opcode fetch) are never stored. Values 2 and 3 are data accesses.
- R6: With `rangeEn` high in access mode, only accesses with `winLo` <= `busAddr` <= `winHi` are stored. If `winLo` > `winHi`, nothing is stored. With `rangeEn` low, the window is ignored.
- R7: In PC mode (mode 3), every `execValid` stores tag 3, address = `execPc`, info 0 and data 0, whether the opcode is legal or not. Change-of-flow events and bus cycles store nothing.
- R8: The memory holds 64 entries. After 64 entries, each new entry overwrites the oldest one, and `entryCount` stays at 64. `rdIdx` 0 always returns the oldest valid entry.
- R9: `clear` sets `entryCount` to 0 on the next cycle and discards any event offered in the same cycle. It also invalidates the shadow register, so the first source event after a clear is always stored.
- R10: An event offered before a rising edge appears in `entryCount` and on the readout after that edge, and not before it.
- R11: After reset, `entryCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear of memory, count and shadow |
| mode | input | 2 | 0 flow, 1 loop-filter, 2 access, 3 PC |
| rangeEn | input | 1 | Enable address window in access mode |
| winLo | input | 16 | Window lower bound (inclusive) |
| winHi | input | 16 | Window upper bound (inclusive) |
| busValid | input | 1 | Bus cycle present |
| cycType | input | 2 | 0 free, 1 opcode fetch, 2/3 data access |
| busAddr | input | 16 | Bus address |
| busData | input | 16 | Bus data |
| busWord | input | 1 | 1 = word access, 0 = byte |
| busWrite | input | 1 | 1 = write, 0 = read |
| cofValid | input | 1 | Change-of-flow event present |
| cofKind | input | 2 | 0 source, 1 destination, 2 vector |
| cofAddr | input | 16 | Change-of-flow address |
| execValid | input | 1 | Opcode executed |
| execPc | input | 16 | PC of executed opcode |
| rdIdx | input | 6 | Readout index, 0 = oldest |
| rdTag | output | 2 | Tag of the entry read |
| rdInfo | output | 8 | Info byte of the entry read |
| rdAddr | output | 16 | Address of the entry read |
| rdData | output | 16 | Data of the entry read |
| entryCount | output | 7 | Number of valid entries (0..64) |

## Verification
The flow-mode tests repeat the same source address and mix in stray bus and execution activity. This shows that flow mode keeps every repeat and ignores the other inputs. The loop-filter stream alternates repeated sources with repeated destinations and vectors that share the shadow address, and it re-offers a pre-clear address after a clear. This pins down which kinds are suppressed and when the shadow is valid. Access-mode stimulus walks all four width and direction combinations, adds free and fetch cycles, and probes the window just outside and exactly on both bounds, including an inverted window. A 70-opcode PC run checks wrap-around and the position of the oldest entry.

// File: rtl/trace_pkg.sv
package trace_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 16;
  parameter int INFO_W = 8;

  typedef enum logic [1:0] {
    MODE_FLOW   = 2'd0,
    MODE_LOOP   = 2'd1,
    MODE_ACCESS = 2'd2,
    MODE_PC     = 2'd3
  } mode_e;

  localparam logic [1:0] TAG_SRC = 2'd0;
  localparam logic [1:0] TAG_DST = 2'd1;
  localparam logic [1:0] TAG_VEC = 2'd2;
  localparam logic [1:0] TAG_ACC = 2'd3;

  localparam logic [1:0] CYC_FREE  = 2'd0;
  localparam logic [1:0] CYC_FETCH = 2'd1;

  typedef struct packed {
    logic [1:0]        tag;
    logic [INFO_W-1:0] info;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } entry_t;

  typedef struct packed {
    logic wr;
    logic clr;
  } strobe_t;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  mode_e             mode,
  input  logic              rangeEn,
  input  logic [ADDR_W-1:0] winLo,
  input  logic [ADDR_W-1:0] winHi,
  input  logic              busValid,
  input  logic [1:0]        cycType,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWord,
  input  logic              busWrite,
  input  logic              cofValid,
  input  logic [1:0]        cofKind,
  input  logic [ADDR_W-1:0] cofAddr,
  input  logic              execValid,
  input  logic [ADDR_W-1:0] execPc,
  output strobe_t           stb,
  output entry_t            wrEntry
);
  logic              shadowValid;
  logic [ADDR_W-1:0] shadowAddr;
  logic              candidate;
  logic              suppress;
  logic              dataCycle;
  logic              inWindow;

  // Bus qualification for access mode
  assign dataCycle = (cycType != CYC_FREE) && (cycType != CYC_FETCH);
  assign inWindow  = !rangeEn || ((busAddr >= winLo) && (busAddr <= winHi));

  always_comb begin
    wrEntry   = '0;
    candidate = 1'b0;
    suppress  = 1'b0;
    unique case (mode)
      MODE_FLOW, MODE_LOOP: begin
        candidate    = cofValid && (cofKind != TAG_ACC);
        wrEntry.tag  = cofKind;
        wrEntry.addr = cofAddr;
        suppress     = (mode == MODE_LOOP) && (cofKind == TAG_SRC) &&
                       shadowValid && (shadowAddr == cofAddr);
      end
      MODE_ACCESS: begin
        candidate    = busValid && dataCycle && inWindow;
        wrEntry.tag  = TAG_ACC;
        wrEntry.info = INFO_W'({busWrite, busWord});
        wrEntry.addr = busAddr;
        wrEntry.data = busData;
      end
      MODE_PC: begin
        candidate    = execValid;
        wrEntry.tag  = TAG_ACC;
        wrEntry.addr = execPc;
      end
      default: ;
    endcase
  end

  assign stb.clr = clear;
  assign stb.wr  = candidate && !suppress && !clear;

  // Shadow of the last address stored in loop-filter mode
  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      shadowValid <= 1'b0;
      shadowAddr  <= '0;
    end else if (stb.wr && (mode == MODE_LOOP)) begin
      shadowValid <= 1'b1;
      shadowAddr  <= wrEntry.addr;
    end
  end
endmodule

// File: rtl/trace_dp.sv
module trace_dp
  import trace_pkg::*;
#(
  parameter int DEPTH_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  entry_t                wrEntry,
  input  logic [DEPTH_LOG2-1:0] rdIdx,
  output entry_t                rdEntry,
  output logic [DEPTH_LOG2:0]   entryCount
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam logic [DEPTH_LOG2:0] FULL = (DEPTH_LOG2 + 1)'(DEPTH);

  entry_t                mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wrPtr;
  logic [DEPTH_LOG2-1:0] oldest;
  logic [DEPTH_LOG2-1:0] phys;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      entryCount <= '0;
    end else if (stb.clr) begin
      wrPtr      <= '0;
      entryCount <= '0;
    end else if (stb.wr) begin
      wrPtr <= wrPtr + 1'b1;
      if (entryCount != FULL) entryCount <= entryCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wr && !stb.clr) mem[wrPtr] <= wrEntry;
  end

  // Once full, the write pointer marks the oldest slot
  assign oldest  = (entryCount == FULL) ? wrPtr : '0;
  assign phys    = oldest + rdIdx;
  assign rdEntry = mem[phys];
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int DEPTH_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clear,
  input  logic [1:0]            mode,
  input  logic                  rangeEn,
  input  logic [ADDR_W-1:0]     winLo,
  input  logic [ADDR_W-1:0]     winHi,
  input  logic                  busValid,
  input  logic [1:0]            cycType,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busData,
  input  logic                  busWord,
  input  logic                  busWrite,
  input  logic                  cofValid,
  input  logic [1:0]            cofKind,
  input  logic [ADDR_W-1:0]     cofAddr,
  input  logic                  execValid,
  input  logic [ADDR_W-1:0]     execPc,
  input  logic [DEPTH_LOG2-1:0] rdIdx,
  output logic [1:0]            rdTag,
  output logic [INFO_W-1:0]     rdInfo,
  output logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic [DEPTH_LOG2:0]   entryCount
);
  strobe_t stb;
  entry_t  wrEntry;
  entry_t  rdEntry;

  trace_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .clear(clear), .mode(mode_e'(mode)),
    .rangeEn(rangeEn), .winLo(winLo), .winHi(winHi),
    .busValid(busValid), .cycType(cycType), .busAddr(busAddr),
    .busData(busData), .busWord(busWord), .busWrite(busWrite),
    .cofValid(cofValid), .cofKind(cofKind), .cofAddr(cofAddr),
    .execValid(execValid), .execPc(execPc),
    .stb(stb), .wrEntry(wrEntry)
  );

  trace_dp #(.DEPTH_LOG2(DEPTH_LOG2)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEntry(wrEntry),
    .rdIdx(rdIdx), .rdEntry(rdEntry), .entryCount(entryCount)
  );

  assign rdTag  = rdEntry.tag;
  assign rdInfo = rdEntry.info;
  assign rdAddr = rdEntry.addr;
  assign rdData = rdEntry.data;
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk
  import trace_pkg::*;
#(
  parameter int DEPTH_LOG2 = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clear,
  input logic [1:0]            mode,
  input logic                  rangeEn,
  input logic [ADDR_W-1:0]     winLo,
  input logic [ADDR_W-1:0]     winHi,
  input logic [1:0]            cycType,
  input logic                  cofValid,
  input logic [1:0]            cofKind,
  input logic [ADDR_W-1:0]     cofAddr,
  input logic                  execValid,
  input logic [DEPTH_LOG2:0]   entryCount
);
  localparam logic [DEPTH_LOG2:0] FULL = (DEPTH_LOG2 + 1)'(1 << DEPTH_LOG2);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= FULL);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> entryCount == '0);

  assert_pc_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && execValid && !clear && entryCount != FULL)
      |=> entryCount == $past(entryCount) + 1'b1);

  assert_skip_free_fetch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && cycType < 2'd2 && !clear) |=> $stable(entryCount));

  assert_empty_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && rangeEn && winLo > winHi && !clear) |=> $stable(entryCount));

  // Second identical source in a row cannot be stored
  assert_loop_repeat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && cofValid && cofKind == 2'd0 && !clear &&
     $past(rstN) && $past(mode == 2'd1 && cofValid && cofKind == 2'd0 && !clear) &&
     cofAddr == $past(cofAddr)) |=> $stable(entryCount));
endmodule

bind trace_capture trace_capture_chk #(.DEPTH_LOG2(DEPTH_LOG2)) chk_i (
  .clk(clk), .rstN(rstN), .clear(clear), .mode(mode), .rangeEn(rangeEn),
  .winLo(winLo), .winHi(winHi), .cycType(cycType), .cofValid(cofValid),
  .cofKind(cofKind), .cofAddr(cofAddr), .execValid(execValid),
  .entryCount(entryCount)
);

// File: tb/trace_capture_tb_top.sv
module trace_capture_tb_top;
  import trace_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic [1:0] mode = 2'd0;
  logic rangeEn = 1'b0;
  logic [15:0] winLo = '0, winHi = '0;
  logic busValid = 1'b0;
  logic [1:0] cycType = '0;
  logic [15:0] busAddr = '0, busData = '0;
  logic busWord = 1'b0, busWrite = 1'b0;
  logic cofValid = 1'b0;
  logic [1:0] cofKind = '0;
  logic [15:0] cofAddr = '0;
  logic execValid = 1'b0;
  logic [15:0] execPc = '0;
  logic [5:0] rdIdx = '0;
  logic [1:0] rdTag;
  logic [7:0] rdInfo;
  logic [15:0] rdAddr, rdData;
  logic [6:0] entryCount;

  int checks = 0;
  int errors = 0;
  entry_t expQ[$];
  logic shValid = 1'b0;
  logic [15:0] shAddr = '0;

  always #4 clk = ~clk;

  trace_capture dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .mode(mode), .rangeEn(rangeEn),
    .winLo(winLo), .winHi(winHi), .busValid(busValid), .cycType(cycType),
    .busAddr(busAddr), .busData(busData), .busWord(busWord), .busWrite(busWrite),
    .cofValid(cofValid), .cofKind(cofKind), .cofAddr(cofAddr),
    .execValid(execValid), .execPc(execPc), .rdIdx(rdIdx), .rdTag(rdTag),
    .rdInfo(rdInfo), .rdAddr(rdAddr), .rdData(rdData), .entryCount(entryCount)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected-entry push: model of the memory and the loop shadow
  task automatic expPush(logic [1:0] tag, logic [7:0] info, logic [15:0] addr, logic [15:0] data);
    entry_t e;
    e.tag = tag; e.info = info; e.addr = addr; e.data = data;
    expQ.push_back(e);
    if (expQ.size() > 64) void'(expQ.pop_front());
    if (mode == 2'd1) begin shValid = 1'b1; shAddr = addr; end
  endtask

  task automatic dropAll();
    busValid = 0; cofValid = 0; execValid = 0; clear = 0;
  endtask

  task automatic cof(logic [1:0] kind, logic [15:0] a);
    @(negedge clk);
    cofValid = 1; cofKind = kind; cofAddr = a;
    if ((mode == 2'd0 || mode == 2'd1) && kind != 2'd3 &&
        !(mode == 2'd1 && kind == 2'd0 && shValid && shAddr == a))
      expPush(kind, 8'h00, a, 16'h0000);
    @(posedge clk); #1 dropAll();
  endtask

  task automatic bus(logic [1:0] ct, logic [15:0] a, logic [15:0] d, logic w, logic wr);
    @(negedge clk);
    busValid = 1; cycType = ct; busAddr = a; busData = d; busWord = w; busWrite = wr;
    if (mode == 2'd2 && ct >= 2'd2 && (!rangeEn || (a >= winLo && a <= winHi)))
      expPush(2'd3, {6'b0, wr, w}, a, d);
    @(posedge clk); #1 dropAll();
  endtask

  task automatic exec(logic [15:0] pc);
    @(negedge clk);
    execValid = 1; execPc = pc;
    if (mode == 2'd3) expPush(2'd3, 8'h00, pc, 16'h0000);
    @(posedge clk); #1 dropAll();
  endtask

  task automatic doClear();
    @(negedge clk);
    clear = 1;
    expQ.delete();
    shValid = 1'b0;
    @(posedge clk); #1 dropAll();
  endtask

  // Monitor: pops expected entries in order and compares the readout
  task automatic drain(string req);
    entry_t tmp[$];
    tmp = expQ;
    @(negedge clk);
    check({req, " count"}, 64'(entryCount), 64'(tmp.size()));
    for (int i = 0; tmp.size() > 0; i++) begin
      entry_t e;
      e = tmp.pop_front();
      rdIdx = 6'(i);
      #1;
      check($sformatf("%s idx %0d", req, i), 64'({rdTag, rdInfo, rdAddr, rdData}), 64'(e));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check("R11 reset count", 64'(entryCount), 64'd0);

    // R1 flow mode: repeats kept, other sources ignored
    mode = 2'd0;
    cof(2'd0, 16'h1234);
    cof(2'd0, 16'h1234);
    cof(2'd1, 16'h2000);
    cof(2'd2, 16'hFFF2);
    cof(2'd3, 16'h5555);
    bus(2'd2, 16'h0100, 16'hAAAA, 1, 1);
    exec(16'h4000);
    drain("R1 flow");

    // R10 latency: no change before the edge, visible after it
    @(negedge clk);
    cofValid = 1; cofKind = 2'd1; cofAddr = 16'h3000;
    #1 check("R10 before edge", 64'(entryCount), 64'd4);
    expPush(2'd1, 8'h00, 16'h3000, 16'h0000);
    @(posedge clk); #1 dropAll();
    check("R10 after edge", 64'(entryCount), 64'd5);

    // R9 clear, with an event in the same cycle discarded
    @(negedge clk);
    clear = 1; cofValid = 1; cofKind = 2'd0; cofAddr = 16'h7777;
    expQ.delete(); shValid = 0;
    @(posedge clk); #1 dropAll();
    drain("R9 clear");

    // R2/R3 loop-filter mode
    mode = 2'd1;
    cof(2'd0, 16'h0A00);
    cof(2'd0, 16'h0A00);
    cof(2'd1, 16'h0B00);
    cof(2'd1, 16'h0B00);
    cof(2'd0, 16'h0B00);
    cof(2'd2, 16'hFFF2);
    cof(2'd2, 16'hFFF2);
    cof(2'd0, 16'h0C00);
    cof(2'd0, 16'h0C00);
    cof(2'd0, 16'h0A00);
    drain("R2 R3 loop");
    check("R2 suppressed count", 64'(entryCount), 64'd7);

    // R9 shadow invalidated by clear
    doClear();
    cof(2'd0, 16'h0A00);
    drain("R9 first source after clear");
    check("R9 stored count", 64'(entryCount), 64'd1);

    // R4/R5 access mode
    doClear();
    mode = 2'd2;
    bus(2'd0, 16'h0010, 16'h1111, 0, 0);
    bus(2'd1, 16'h0020, 16'h2222, 1, 0);
    bus(2'd2, 16'h0030, 16'h0033, 0, 0);
    bus(2'd2, 16'h0040, 16'h4444, 1, 1);
    bus(2'd3, 16'h0050, 16'h5555, 1, 0);
    bus(2'd2, 16'h0060, 16'h0066, 0, 1);
    cof(2'd0, 16'h0070);
    exec(16'h0080);
    drain("R4 R5 access");

    // R6 window
    doClear();
    rangeEn = 1; winLo = 16'h0100; winHi = 16'h01FF;
    bus(2'd2, 16'h00FF, 16'h0001, 0, 0);
    bus(2'd2, 16'h0100, 16'h0002, 0, 0);
    bus(2'd2, 16'h01FF, 16'h0003, 1, 1);
    bus(2'd2, 16'h0200, 16'h0004, 0, 1);
    winLo = 16'h0300; winHi = 16'h0200;
    bus(2'd2, 16'h0250, 16'h0005, 0, 0);
    rangeEn = 0;
    bus(2'd2, 16'h0250, 16'h0006, 0, 0);
    drain("R6 window");

    // R7 PC mode and R8 wrap
    doClear();
    mode = 2'd3;
    cof(2'd1, 16'h0900);
    bus(2'd2, 16'h0901, 16'h0000, 0, 0);
    for (int i = 0; i < 70; i++) exec(16'h8000 + 16'(i * 3));
    drain("R7 R8 pc wrap");
    @(negedge clk);
    rdIdx = 6'd0; #1;
    check("R8 oldest after wrap", 64'(rdAddr), 64'(16'h8000 + 16'(6 * 3)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule